// File: doc/BRIEF.md
# DDR2 Controller Mode and Register Control Unit

This unit is the software-facing control plane of a DDR2 memory controller. Software reaches it through a simple single-cycle register bus: a write strobe with address and 32-bit data, and a read data bus that always reflects the register at the current address. The unit holds the controller's operating mode, the timing and memory geometry settings, the per-ID quality-of-service settings, the pad-calibration handshake and one feature control bit.

A three-state machine governs the mode. The states are CONFIG, where setup is allowed; WARMUP, a fixed-length transition that stands in for the pending memory initialisation; and READY. The transitions are: CONFIG to WARMUP on a GO command; WARMUP to READY when the delay counter runs out; and any state to CONFIG on a CONFIG command. The timing and geometry registers accept writes only in CONFIG. A write to one of them in any other mode is discarded and raises a sticky error flag. The flag is cleared by the next CONFIG command.

A write to the pad-drive user register starts impedance calibration. The unit raises its calibration request until the pad logic answers with a done pulse, and then reports completion in the user status register. Both user registers are write-only and read back as zero.

Top module: `mcm_ctl`

## Requirements
- R1: After reset the mode is CONFIG (status bits [5:4] = 0), `ctl_ready`, `cfg_err`, `cal_req` and `early_resp_off` are 0, and every register reads zero.
- R2: A write of 1 (GO) to the command register at 0x000 while in CONFIG enters WARMUP (mode code 1). `ctl_ready` and status bit 0 become 1, with mode code 2, exactly GO_DELAY clock edges after the edge that took the GO write.
- R3: A write of 2 (CONFIG) to 0x000 returns the unit to CONFIG on the next edge from any state, clears `cfg_err` and drops `ctl_ready`. GO outside CONFIG and any other command value change nothing.
- R4: The 25 protected registers at 0x040 + 4*i (i = 0..17 are timing, i = 18..24 are memory geometry) store all 32 bits when written in CONFIG and read back what was written.
- R5: A write to a protected register outside CONFIG leaves its value unchanged and sets `cfg_err`, also visible as status bit 1. The flag then stays set until a CONFIG command.
- R6: The 16 QoS registers at 0x100 + 4*i keep bit 0 (enable) and bits [4:1] (minimum latency) in any mode, and read zero above bit 4.
- R7: The user registers at 0x200 (DLL setting, output `phy_dll_cfg`) and 0x204 (pad drive, output `pad_drive_cfg`) read as zero. A write to 0x204 clears user status bit 8 (at 0x208) and raises `cal_req`. `cal_req` falls and bit 8 is set on the edge where `cal_done` is seen high.
- R8: Bit 0 of the feature register at 0x20C drives `early_resp_off`, which disables the early write response, and reads back. Its other bits read zero.
- R9: Reads of the command register, of misaligned addresses and of any unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cal_done | input | 1 | Pad calibration finished pulse |
| cal_req | output | 1 | Pad calibration request |
| ctl_ready | output | 1 | Controller is in READY |
| cfg_err | output | 1 | Sticky flag: protected write was refused |
| early_resp_off | output | 1 | Early write response disabled |
| phy_dll_cfg | output | 32 | Value of the DLL user register |
| pad_drive_cfg | output | 32 | Value of the pad-drive user register |

## Verification
The assertions watch the mode machine on every cycle. They check that READY is only ever entered from WARMUP, that a CONFIG command always lands in CONFIG with the error flag cleared, and that a refused protected write always raises a flag that then holds. They also check that the calibration request starts on a pad-drive write and ends on `cal_done`, and that the write-only registers never read back. The exact GO_DELAY count, the register contents left untouched by refused writes, the QoS bit masking and the read value of every region can only be shown by the bench. It runs scenarios against its own reference model and compares every output and the read data on each clock.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

    typedef enum logic [1:0] {
        MODE_CFG  = 2'd0,
        MODE_WARM = 2'd1,
        MODE_RDY  = 2'd2
    } mode_t;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CMD   = 12'h000;
    localparam logic [ADDR_W-1:0] A_STAT  = 12'h004;
    localparam logic [ADDR_W-1:0] A_PROT  = 12'h040;
    localparam logic [ADDR_W-1:0] A_QOS   = 12'h100;
    localparam logic [ADDR_W-1:0] A_USR0  = 12'h200;
    localparam logic [ADDR_W-1:0] A_USR2  = 12'h204;
    localparam logic [ADDR_W-1:0] A_USTAT = 12'h208;
    localparam logic [ADDR_W-1:0] A_FEAT  = 12'h20C;

    localparam logic [DATA_W-1:0] CMD_GO  = 32'd1;
    localparam logic [DATA_W-1:0] CMD_CFG = 32'd2;

    localparam int N_TIMING = 18;
    localparam int N_GEOM   = 7;
    localparam int PROT_N   = N_TIMING + N_GEOM;
    localparam int QOS_N    = 16;
    localparam int QOS_W    = 5;
    localparam int CAL_BIT  = 8;

endpackage

// File: rtl/mcm_mode_fsm.sv
module mcm_mode_fsm
    import mcm_pkg::*;
#(
    parameter int GO_DELAY = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go_cmd,
    input  logic  cfg_cmd,
    output mode_t mode,
    output logic  ready
);
    localparam int CNT_W = $clog2(GO_DELAY + 1);

    mode_t            state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CFG:  if (go_cmd) state_d = MODE_WARM;
            MODE_WARM: if (cnt_q == '0) state_d = MODE_RDY;
            MODE_RDY:  state_d = MODE_RDY;
            default:   state_d = MODE_CFG;
        endcase
        if (cfg_cmd) state_d = MODE_CFG;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_CFG;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cfg_cmd)
            cnt_q <= '0;
        else if (state_q == MODE_CFG && go_cmd)
            cnt_q <= CNT_W'(GO_DELAY - 1);
        else if (state_q == MODE_WARM && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        mode  = state_q;
        ready = (state_q == MODE_RDY);
    end

endmodule

// File: rtl/mcm_prot_bank.sv
module mcm_prot_bank #(
    parameter int N  = 25,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic                 wr,
    input  logic [$clog2(N)-1:0] idx,
    input  logic [DW-1:0]        wdata,
    input  logic                 allow,
    input  logic                 clr_err,
    output logic [DW-1:0]        rdata,
    output logic                 err
);
    logic [DW-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (hit && wr && allow && idx == i)
                regs[i] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err <= 1'b0;
        else if (clr_err)
            err <= 1'b0;
        else if (hit && wr && !allow)
            err <= 1'b1;
    end

    always_comb begin
        rdata = '0;
        if (hit) rdata = regs[idx];
    end

endmodule

// File: rtl/mcm_qos_bank.sv
module mcm_qos_bank #(
    parameter int N  = 16,
    parameter int QW = 5,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic                 wr,
    input  logic [$clog2(N)-1:0] idx,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata
);
    logic [QW-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_qos
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (hit && wr && idx == i)
                regs[i] <= wdata[QW-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) rdata = DW'(regs[idx]);
    end

endmodule

// File: rtl/mcm_user_cal.sv
module mcm_user_cal #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_dll,
    input  logic          wr_pad,
    input  logic          wr_feat,
    input  logic [DW-1:0] wdata,
    input  logic          cal_done,
    output logic [DW-1:0] dll_q,
    output logic [DW-1:0] pad_q,
    output logic          cal_req,
    output logic          cal_ok,
    output logic          feat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_q  <= '0;
            pad_q  <= '0;
            feat_q <= 1'b0;
        end else begin
            if (wr_dll)  dll_q  <= wdata;
            if (wr_pad)  pad_q  <= wdata;
            if (wr_feat) feat_q <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_req <= 1'b0;
            cal_ok  <= 1'b0;
        end else if (wr_pad) begin
            cal_req <= 1'b1;
            cal_ok  <= 1'b0;
        end else if (cal_req && cal_done) begin
            cal_req <= 1'b0;
            cal_ok  <= 1'b1;
        end
    end

endmodule

// File: rtl/mcm_ctl.sv
module mcm_ctl
    import mcm_pkg::*;
#(
    parameter int GO_DELAY = 8,
    parameter int N_PROT   = PROT_N,
    parameter int N_QOSREG = QOS_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cal_done,
    output logic              cal_req,
    output logic              ctl_ready,
    output logic              cfg_err,
    output logic              early_resp_off,
    output logic [DATA_W-1:0] phy_dll_cfg,
    output logic [DATA_W-1:0] pad_drive_cfg
);
    localparam int PIDX_W = $clog2(N_PROT);
    localparam int QIDX_W = $clog2(N_QOSREG);
    localparam logic [ADDR_W-1:0] PROT_END = A_PROT + ADDR_W'(4 * N_PROT);
    localparam logic [ADDR_W-1:0] QOS_END  = A_QOS + ADDR_W'(4 * N_QOSREG);

    mode_t mode_q;
    logic  go_cmd, cfg_cmd, aligned;
    logic  prot_hit, qos_hit;
    logic  [PIDX_W-1:0] prot_idx;
    logic  [QIDX_W-1:0] qos_idx;
    logic  [DATA_W-1:0] prot_rd, qos_rd;
    logic  cal_ok;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        go_cmd   = bus_wr && bus_addr == A_CMD && bus_wdata == CMD_GO;
        cfg_cmd  = bus_wr && bus_addr == A_CMD && bus_wdata == CMD_CFG;
        prot_hit = aligned && bus_addr >= A_PROT && bus_addr < PROT_END;
        qos_hit  = aligned && bus_addr >= A_QOS && bus_addr < QOS_END;
        prot_idx = PIDX_W'((bus_addr - A_PROT) >> 2);
        qos_idx  = QIDX_W'((bus_addr - A_QOS) >> 2);
    end

    mcm_mode_fsm #(.GO_DELAY(GO_DELAY)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_cmd  (go_cmd),
        .cfg_cmd (cfg_cmd),
        .mode    (mode_q),
        .ready   (ctl_ready)
    );

    mcm_prot_bank #(.N(N_PROT), .DW(DATA_W)) u_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (prot_hit),
        .wr      (bus_wr),
        .idx     (prot_idx),
        .wdata   (bus_wdata),
        .allow   (mode_q == MODE_CFG),
        .clr_err (cfg_cmd),
        .rdata   (prot_rd),
        .err     (cfg_err)
    );

    mcm_qos_bank #(.N(N_QOSREG), .QW(QOS_W), .DW(DATA_W)) u_qos (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (qos_hit),
        .wr    (bus_wr),
        .idx   (qos_idx),
        .wdata (bus_wdata),
        .rdata (qos_rd)
    );

    mcm_user_cal #(.DW(DATA_W)) u_user (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_dll   (bus_wr && bus_addr == A_USR0),
        .wr_pad   (bus_wr && bus_addr == A_USR2),
        .wr_feat  (bus_wr && bus_addr == A_FEAT),
        .wdata    (bus_wdata),
        .cal_done (cal_done),
        .dll_q    (phy_dll_cfg),
        .pad_q    (pad_drive_cfg),
        .cal_req  (cal_req),
        .cal_ok   (cal_ok),
        .feat_q   (early_resp_off)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT)
            bus_rdata = {{(DATA_W-6){1'b0}}, mode_q, 2'b00, cfg_err, ctl_ready};
        else if (bus_addr == A_USTAT)
            bus_rdata = DATA_W'({cal_ok, {CAL_BIT{1'b0}}});
        else if (bus_addr == A_FEAT)
            bus_rdata = DATA_W'(early_resp_off);
        else if (prot_hit)
            bus_rdata = prot_rd;
        else if (qos_hit)
            bus_rdata = qos_rd;
    end

endmodule

// File: rtl/mcm_ctl_checker.sv
module mcm_ctl_checker
    import mcm_pkg::*;
#(
    parameter int N_PROT = PROT_N
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cal_done,
    input logic              cal_req,
    input logic              ctl_ready,
    input logic              cfg_err,
    input mode_t             mode
);
    localparam logic [ADDR_W-1:0] P_END = A_PROT + ADDR_W'(4 * N_PROT);

    logic cfg_wr, go_wr, prot_wr, pad_wr;
    always_comb begin
        cfg_wr  = bus_wr && bus_addr == A_CMD && bus_wdata == CMD_CFG;
        go_wr   = bus_wr && bus_addr == A_CMD && bus_wdata == CMD_GO;
        prot_wr = bus_wr && bus_addr[1:0] == 2'b00 && bus_addr >= A_PROT && bus_addr < P_END;
        pad_wr  = bus_wr && bus_addr == A_USR2;
    end

    // R2: READY is reached only through WARMUP
    p_ready_from_warm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_ready) |-> $past(mode) == MODE_WARM);

    // R3: CONFIG command always lands in CONFIG with a clean flag
    p_cfg_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (mode == MODE_CFG && !cfg_err && !ctl_ready));

    // R3: GO in READY has no effect
    p_go_in_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && mode == MODE_RDY) |=> mode == MODE_RDY);

    // R5: refused protected write raises the flag
    p_block_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && mode != MODE_CFG) |=> cfg_err);

    // R5: the flag holds until a CONFIG command
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !cfg_wr) |=> cfg_err);

    // R7: pad-drive write starts calibration
    p_cal_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pad_wr |=> cal_req);

    // R7: done pulse ends calibration
    p_cal_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req && cal_done && !pad_wr) |=> !cal_req);

    // R7: user registers are write-only
    p_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_USR0 || bus_addr == A_USR2) |-> bus_rdata == '0);

endmodule

bind mcm_ctl mcm_ctl_checker #(.N_PROT(N_PROT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cal_done  (cal_done),
    .cal_req   (cal_req),
    .ctl_ready (ctl_ready),
    .cfg_err   (cfg_err),
    .mode      (mode_q)
);

// File: tb/mcm_ctl_test.sv
`timescale 1ns/1ps
module mcm_ctl_test;
    localparam int GD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'hFFC;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cal_done = 1'b0;
    logic        cal_req, ctl_ready, cfg_err, early_resp_off;
    logic [31:0] phy_dll_cfg, pad_drive_cfg;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mcm_ctl #(.GO_DELAY(GD)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cal_done(cal_done),
        .cal_req(cal_req), .ctl_ready(ctl_ready), .cfg_err(cfg_err),
        .early_resp_off(early_resp_off), .phy_dll_cfg(phy_dll_cfg),
        .pad_drive_cfg(pad_drive_cfg)
    );

    // behavioural reference model
    int          m_mode, m_cnt;
    bit          m_err, m_busy, m_calok, m_feat;
    logic [31:0] m_prot [25];
    logic [31:0] m_qos [16];
    logic [31:0] m_dll, m_pad;

    function automatic logic [31:0] model_read(logic [11:0] a);
        int off;
        if (a == 12'h004) return {26'd0, 2'(m_mode), 2'b00, m_err, m_mode == 2};
        if (a == 12'h208) return m_calok ? 32'h100 : 32'h0;
        if (a == 12'h20C) return {31'd0, m_feat};
        if (a[1:0] != 2'b00) return 32'h0;
        off = int'(a);
        if (off >= 'h40 && off < 'h40 + 4 * 25) return m_prot[(off - 'h40) / 4];
        if (off >= 'h100 && off < 'h100 + 4 * 16) return m_qos[(off - 'h100) / 4];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_err = 0; m_busy = 0; m_calok = 0; m_feat = 0;
            m_dll = 0; m_pad = 0;
            foreach (m_prot[i]) m_prot[i] = 0;
            foreach (m_qos[i]) m_qos[i] = 0;
        end else begin
            int off;
            int old_mode;
            off = int'(bus_addr);
            old_mode = m_mode;
            if (m_mode == 1) begin
                m_cnt--;
                if (m_cnt == 0) m_mode = 2;
            end
            if (bus_wr) begin
                if (off == 0 && bus_wdata == 2) begin
                    m_mode = 0; m_err = 0;
                end else if (off == 0 && bus_wdata == 1 && old_mode == 0) begin
                    m_mode = 1; m_cnt = GD;
                end
                if (bus_addr[1:0] == 0 && off >= 'h40 && off < 'h40 + 4 * 25) begin
                    if (old_mode == 0) m_prot[(off - 'h40) / 4] = bus_wdata;
                    else m_err = 1;
                end
                if (bus_addr[1:0] == 0 && off >= 'h100 && off < 'h100 + 4 * 16)
                    m_qos[(off - 'h100) / 4] = bus_wdata & 32'h1F;
                if (off == 'h200) m_dll = bus_wdata;
                if (off == 'h20C) m_feat = bus_wdata[0];
            end
            if (bus_wr && off == 'h204) begin
                m_pad = bus_wdata; m_busy = 1; m_calok = 0;
            end else if (m_busy && cal_done) begin
                m_busy = 0; m_calok = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check(ctl_ready == (m_mode == 2), "R2", "ctl_ready", 32'(ctl_ready), 32'(m_mode == 2));
            check(cfg_err == m_err, "R5", "cfg_err", 32'(cfg_err), 32'(m_err));
            check(cal_req == m_busy, "R7", "cal_req", 32'(cal_req), 32'(m_busy));
            check(early_resp_off == m_feat, "R8", "early_resp_off", 32'(early_resp_off), 32'(m_feat));
            check(phy_dll_cfg == m_dll, "R7", "phy_dll_cfg", phy_dll_cfg, m_dll);
            check(pad_drive_cfg == m_pad, "R7", "pad_drive_cfg", pad_drive_cfg, m_pad);
            check(bus_rdata == model_read(bus_addr), "R9", "bus_rdata", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 12'hFFC; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, tag, "read", bus_rdata, exp);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(!ctl_ready && !cfg_err && !cal_req && !early_resp_off, "R1", "outputs",
              {ctl_ready, cfg_err, cal_req, early_resp_off}, 32'h0);
        rd(12'h004, 32'h0, "R1");
        rd(12'h040, 32'h0, "R1");
        rd(12'h13C, 32'h0, "R1");

        // R4 protected registers in CONFIG
        for (int i = 0; i < 25; i++) wr(12'(12'h040 + 4 * i), 32'hA500_0000 + 32'(i * 3));
        rd(12'h040, 32'hA500_0000, "R4");
        rd(12'h0A0, 32'hA500_0048, "R4");
        rd(12'h084, 32'hA500_0033, "R4");

        // R6 QoS masking
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h13C, 32'h0000_0016);
        rd(12'h100, 32'h1F, "R6");
        rd(12'h13C, 32'h16, "R6");

        // R9 unmapped / misaligned / command
        rd(12'h000, 32'h0, "R9");
        rd(12'h042, 32'h0, "R9");
        rd(12'h0A4, 32'h0, "R9");
        rd(12'h300, 32'h0, "R9");

        // R7 write-only user registers and calibration
        wr(12'h200, 32'h1234_5678);
        rd(12'h200, 32'h0, "R7");
        wr(12'h204, 32'h4000_0198);
        rd(12'h204, 32'h0, "R7");
        check(cal_req == 1'b1, "R7", "cal_req raised", 32'(cal_req), 32'h1);
        rd(12'h208, 32'h0, "R7");
        repeat (4) @(negedge clk);
        check(cal_req == 1'b1, "R7", "cal_req held", 32'(cal_req), 32'h1);
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
        check(cal_req == 1'b0, "R7", "cal_req dropped", 32'(cal_req), 32'h0);
        rd(12'h208, 32'h100, "R7");
        wr(12'h204, 32'h4080_0005);
        rd(12'h208, 32'h0, "R7");
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;

        // R8 feature bit
        wr(12'h20C, 32'hFFFF_FFFF);
        rd(12'h20C, 32'h1, "R8");
        check(early_resp_off == 1'b1, "R8", "early_resp_off", 32'(early_resp_off), 32'h1);

        // R3 unknown command ignored
        wr(12'h000, 32'h7);
        rd(12'h004, 32'h0, "R3");

        // R2 GO delay
        wr(12'h000, 32'h1);
        for (int k = 1; k < GD; k++) begin
            @(negedge clk);
            check(!ctl_ready, "R2", "early ready", 32'(ctl_ready), 32'h0);
        end
        @(negedge clk);
        check(ctl_ready, "R2", "ready after GO_DELAY", 32'(ctl_ready), 32'h1);
        rd(12'h004, 32'h21, "R2");

        // R5 refused write in READY
        wr(12'h044, 32'hDEAD_BEEF);
        rd(12'h044, 32'hA500_0003, "R5");
        rd(12'h004, 32'h23, "R5");
        wr(12'h000, 32'h1);
        rd(12'h004, 32'h23, "R3");

        // R3 CONFIG from READY clears error
        wr(12'h000, 32'h2);
        rd(12'h004, 32'h0, "R3");

        // R3 CONFIG from WARMUP, R5 refused write in WARMUP
        wr(12'h000, 32'h1);
        wr(12'h048, 32'h0BAD_0000);
        rd(12'h004, 32'h12, "R5");
        rd(12'h048, 32'hA500_0006, "R5");
        wr(12'h000, 32'h2);
        rd(12'h004, 32'h0, "R3");
        repeat (GD + 2) @(negedge clk);
        check(!ctl_ready, "R3", "stays in CONFIG", 32'(ctl_ready), 32'h0);
        wr(12'h048, 32'h0000_00C3);
        rd(12'h048, 32'hC3, "R4");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule